// File: doc/BRIEF.md
# Gate Override and Manual Reset Controller

This block decides whether the enable for an external pass transistor on the hot side of a supply may be on. Three things can hold the gate off. The first is an active-low hot-side manual reset pin. The second is an override bit that a host sets through a simple strobe-based register write. The third is a fault-alarm flag that fault detection logic sets. Releasing the manual reset pin, or having the host clear its override, produces a one-clock restart request that starts a fresh power-up sequence.

The hot-side pin also acts as a clearing action. While it is low, the override bit and the fault-alarm flag are held clear, and any host write or fault report that arrives in that time is dropped. A second active-low pin acts on the cold side. It forces the registered power-good indicator inactive and leaves the gate alone. Both pins are asynchronous and pass through a multi-flop synchronizer before any logic uses them.

Top module: `gate_ovr_ctl`

## Requirements
- R1: During reset every output is 0. After reset is released with both pins high, `gate_en` goes high after the 2nd rising edge. One `restart` pulse follows after the 3rd edge, and `pg_out` follows `pg_in` from the 3rd edge onward.
- R2: `gate_en` drops after the 2nd rising edge following a fall of `hot_mr_n`. Until then it keeps its prior value.
- R3: The hot-side clear works as follows. `ovr_status` and `fault_alarm` are 0 one edge after `gate_en` is forced off by `hot_mr_n`, and they stay 0 while `hot_mr_n` is low. A set write or a `fault_in` pulse in that time has no effect.
- R4: A write (`reg_wr`=1) to address 3 with data bit 0 = 1 sets the override on that edge: `ovr_status`=1 and `gate_en`=0. A write to any other address changes nothing.
- R5: A write to address 3 with data bit 0 = 0 while the override is set clears it on that edge and raises `restart` for exactly one cycle. The same write while the override is already clear gives no pulse.
- R6: After `hot_mr_n` rises, `gate_en` returns high after the 2nd edge when no fault or override is pending. `restart` is high for one cycle after the 3rd edge.
- R7: `fault_in`=1 at an edge sets `fault_alarm` and turns `gate_en` off. The alarm stays set until a hot-side manual reset.
- R8: `pg_out` is `pg_in` registered one edge, gated by the synchronized `cold_mr_n`. A fall of `cold_mr_n` forces `pg_out` to 0 after the 3rd edge, and `cold_mr_n` never affects `gate_en`.
- R9: `gate_en` stays 0 while the override and the fault alarm are both set, and the override then shows on `ovr_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hot_mr_n | input | 1 | Hot-side manual reset, active low, asynchronous |
| cold_mr_n | input | 1 | Cold-side manual reset, active low, asynchronous |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | DATA_W | Register write data |
| fault_in | input | 1 | Fault report from detection logic, synchronous |
| pg_in | input | 1 | Power-good request from the sequencer, synchronous |
| gate_en | output | 1 | Enable for the pass transistor gate drive |
| ovr_status | output | 1 | Host override is active |
| fault_alarm | output | 1 | Fault-alarm flag |
| restart | output | 1 | One-cycle power-up restart request |
| pg_out | output | 1 | Power-good indicator |

## Verification
Each result has a fixed latency. A pin change reaches `gate_en` two edges later. It reaches the override and alarm clear, the restart pulse and `pg_out` three edges later. A register write or fault report shows after one edge, and a `pg_in` change after one edge. The driver drives at falling edges and records every expected output vector against the absolute cycle in which it is due, for example two cycles after a pin write. The monitor compares the complete output vector at the falling edge of exactly that cycle. It treats any entry whose cycle has passed unmatched as a failure, so an output that arrives a cycle early or late is caught, not only a wrong value.

// File: rtl/gov_pkg.sv
package gov_pkg;

   typedef struct packed {
      logic gate;
      logic ovr;
      logic flt;
      logic rst;
      logic pg;
   } gov_stat_t;

   function automatic logic rise_of(input logic now_v, input logic prev_v);
      return now_v & ~prev_v;
   endfunction

endpackage

// File: rtl/gov_sync.sv
module gov_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
               else        chain[s] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gov_shdn_reg.sv
module gov_shdn_reg #(
   parameter int ADDR_W    = 4,
   parameter int SHDN_ADDR = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_hot,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wbit,
   input  logic              fault_in,
   output logic              ovr_q,
   output logic              flt_q,
   output logic              host_rel
);
   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(SHDN_ADDR);

   logic hit;
   assign hit = wr && (addr == HIT_ADDR);

   // Clearing by the hot-side pin outranks every set source.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         flt_q <= 1'b0;
      end else if (!s_hot) begin
         ovr_q <= 1'b0;
         flt_q <= 1'b0;
      end else begin
         if (hit)      ovr_q <= wbit;
         if (fault_in) flt_q <= 1'b1;
      end
   end

   // A release counts only when an override is actually dropped by the host.
   assign host_rel = hit && !wbit && ovr_q && s_hot;
endmodule

// File: rtl/gov_restart.sv
module gov_restart (
   input  logic clk,
   input  logic rst_n,
   input  logic s_hot,
   input  logic host_rel,
   output logic restart_q
);
   import gov_pkg::*;

   logic s_hot_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_hot_d   <= 1'b0;
         restart_q <= 1'b0;
      end else begin
         s_hot_d   <= s_hot;
         restart_q <= rise_of(s_hot, s_hot_d) | host_rel;
      end
   end
endmodule

// File: rtl/gate_ovr_ctl.sv
module gate_ovr_ctl #(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int SHDN_ADDR   = 3,
   parameter int OVR_BIT     = 0,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hot_mr_n,
   input  logic              cold_mr_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              fault_in,
   input  logic              pg_in,
   output logic              gate_en,
   output logic              ovr_status,
   output logic              fault_alarm,
   output logic              restart,
   output logic              pg_out
);
   import gov_pkg::*;

   localparam int PIN_W = 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gate_ovr_ctl: SYNC_STAGES must be at least 2");
      end
      if (OVR_BIT < 0 || OVR_BIT >= DATA_W) begin : g_bad_bit
         $error("gate_ovr_ctl: OVR_BIT outside data word");
      end
      if (SHDN_ADDR < 0 || SHDN_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("gate_ovr_ctl: SHDN_ADDR outside address space");
      end
   endgenerate

   logic [PIN_W-1:0] pins_s;
   logic             s_hot, s_cold;
   logic             ovr_q, flt_q, host_rel, restart_q, pg_q;
   logic             unused_wdata;
   gov_stat_t        st;

   gov_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({hot_mr_n, cold_mr_n}),
      .q     (pins_s)
   );
   assign s_hot  = pins_s[1];
   assign s_cold = pins_s[0];

   gov_shdn_reg #(.ADDR_W(ADDR_W), .SHDN_ADDR(SHDN_ADDR)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_hot    (s_hot),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wbit     (reg_wdata[OVR_BIT]),
      .fault_in (fault_in),
      .ovr_q    (ovr_q),
      .flt_q    (flt_q),
      .host_rel (host_rel)
   );

   gov_restart u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_hot     (s_hot),
      .host_rel  (host_rel),
      .restart_q (restart_q)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pg_q <= 1'b0;
      else        pg_q <= pg_in & s_cold;

   assign unused_wdata = ^reg_wdata;

   always_comb begin
      st.gate = s_hot & ~ovr_q & ~flt_q;
      st.ovr  = ovr_q;
      st.flt  = flt_q;
      st.rst  = restart_q;
      st.pg   = pg_q;
   end

   assign gate_en     = st.gate;
   assign ovr_status  = st.ovr;
   assign fault_alarm = st.flt;
   assign restart     = st.rst;
   assign pg_out      = st.pg;
endmodule

// File: rtl/gov_chk.sv
module gov_chk #(
   parameter int ADDR_W    = 4,
   parameter int SHDN_ADDR = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_hot,
   input logic              s_cold,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              wbit,
   input logic              fault_in,
   input logic              gate_en,
   input logic              ovr_status,
   input logic              fault_alarm,
   input logic              restart,
   input logic              pg_out
);
   logic hit;
   assign hit = reg_wr && (reg_addr == ADDR_W'(SHDN_ADDR));

   p_gate_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !s_hot |-> !gate_en);

   p_clear_hot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !s_hot |=> (!ovr_status && !fault_alarm));

   p_set_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_hot && hit && wbit) |=> (ovr_status && !gate_en));

   p_rel_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_hot && hit && !wbit && ovr_status) |=> (restart && !ovr_status));

   p_rise_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_hot) |=> restart);

   p_fault_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_hot && fault_in) |=> (fault_alarm && !gate_en));

   p_cold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !s_cold |=> !pg_out);
endmodule

bind gate_ovr_ctl gov_chk #(.ADDR_W(ADDR_W), .SHDN_ADDR(SHDN_ADDR)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .s_hot       (s_hot),
   .s_cold      (s_cold),
   .reg_wr      (reg_wr),
   .reg_addr    (reg_addr),
   .wbit        (reg_wdata[OVR_BIT]),
   .fault_in    (fault_in),
   .gate_en     (gate_en),
   .ovr_status  (ovr_status),
   .fault_alarm (fault_alarm),
   .restart     (restart),
   .pg_out      (pg_out)
);

// File: tb/gate_ovr_ctl_test.sv
module gate_ovr_ctl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hot_mr_n = 1'b1;
   logic       cold_mr_n = 1'b1;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       fault_in = 1'b0;
   logic       pg_in = 1'b1;
   logic       gate_en, ovr_status, fault_alarm, restart, pg_out;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   int         q_cyc[$];
   logic [4:0] q_exp[$];
   string      q_tag[$];

   gate_ovr_ctl uut (
      .clk(clk), .rst_n(rst_n), .hot_mr_n(hot_mr_n), .cold_mr_n(cold_mr_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .fault_in(fault_in), .pg_in(pg_in), .gate_en(gate_en),
      .ovr_status(ovr_status), .fault_alarm(fault_alarm),
      .restart(restart), .pg_out(pg_out)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Vector order: {gate_en, ovr_status, fault_alarm, restart, pg_out}
   task automatic expect_at(input int ofs, input logic [4:0] v, input string tag);
      q_cyc.push_back(cyc + ofs);
      q_exp.push_back(v);
      q_tag.push_back(tag);
   endtask

   // Monitor: compares each expected vector in the cycle it is due
   always @(negedge clk) begin
      while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
         logic [4:0] act;
         act = {gate_en, ovr_status, fault_alarm, restart, pg_out};
         n_chk++;
         if (q_cyc[0] < cyc) begin
            n_fail++;
            $display("FAIL %s: check for cycle %0d missed (now %0d), actual %b expected %b",
                     q_tag[0], q_cyc[0], cyc, act, q_exp[0]);
         end else if (act !== q_exp[0]) begin
            n_fail++;
            $display("FAIL %s: cycle %0d actual %b expected %b", q_tag[0], cyc, act, q_exp[0]);
         end
         void'(q_cyc.pop_front());
         void'(q_exp.pop_front());
         void'(q_tag.pop_front());
      end
   end

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         reg_wr   = 1'b0;
         fault_in = 1'b0;
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_wr    = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      idle(2);
      expect_at(1, 5'b00000, "R1 outputs in reset");
      idle(3);
      rst_n = 1'b1;
      expect_at(1, 5'b00000, "R1 first edge after reset");
      expect_at(2, 5'b10000, "R1 gate up after two edges");
      expect_at(3, 5'b10011, "R1 restart pulse and power good");
      expect_at(4, 5'b10001, "R1 pulse ends");
      idle(6);

      // Hot-side pin alone
      hot_mr_n = 1'b0;
      expect_at(1, 5'b10001, "R2 gate held during sync");
      expect_at(2, 5'b00001, "R2 gate forced off");
      idle(5);
      hot_mr_n = 1'b1;
      expect_at(1, 5'b00001, "R6 gate off during sync");
      expect_at(2, 5'b10001, "R6 gate back on");
      expect_at(3, 5'b10011, "R6 restart pulse");
      expect_at(4, 5'b10001, "R6 pulse single cycle");
      idle(6);

      // Host override
      wr(4'd3, 8'h01);
      expect_at(1, 5'b01001, "R4 override set");
      idle(2);
      wr(4'd5, 8'h00);
      expect_at(1, 5'b01001, "R4 other address ignored");
      idle(2);
      wr(4'd3, 8'h00);
      expect_at(1, 5'b10011, "R5 release pulse");
      expect_at(2, 5'b10001, "R5 pulse single cycle");
      idle(3);
      wr(4'd3, 8'h00);
      expect_at(1, 5'b10001, "R5 no pulse without override");
      idle(2);

      // Fault alarm, then override on top of it
      fault_in = 1'b1;
      expect_at(1, 5'b00101, "R7 fault sets alarm");
      expect_at(3, 5'b00101, "R7 alarm held");
      idle(4);
      wr(4'd3, 8'h01);
      expect_at(1, 5'b01101, "R9 override and alarm both set");
      idle(2);

      // Hot-side pin clears override and alarm
      hot_mr_n = 1'b0;
      expect_at(2, 5'b01101, "R3 state kept until clear edge");
      expect_at(3, 5'b00001, "R3 override and alarm cleared");
      idle(4);
      wr(4'd3, 8'h01);
      expect_at(1, 5'b00001, "R3 set write ignored while pin low");
      idle(2);
      fault_in = 1'b1;
      expect_at(1, 5'b00001, "R3 fault ignored while pin low");
      idle(2);
      hot_mr_n = 1'b1;
      expect_at(1, 5'b00001, "R6 still off during sync");
      expect_at(2, 5'b10001, "R6 gate on with override removed");
      expect_at(3, 5'b10011, "R6 restart after release");
      expect_at(4, 5'b10001, "R6 pulse ends");
      idle(5);

      // Cold-side pin and power-good path
      cold_mr_n = 1'b0;
      expect_at(2, 5'b10001, "R8 power good kept during sync");
      expect_at(3, 5'b10000, "R8 power good forced off, gate unaffected");
      idle(4);
      cold_mr_n = 1'b1;
      expect_at(2, 5'b10000, "R8 still off during sync");
      expect_at(3, 5'b10001, "R8 power good restored");
      idle(4);
      pg_in = 1'b0;
      expect_at(1, 5'b10000, "R8 power good follows request low");
      idle(2);
      pg_in = 1'b1;
      expect_at(1, 5'b10001, "R8 power good follows request high");
      idle(3);

      if (q_cyc.size() != 0) begin
         n_fail++;
         $display("FAIL R1: %0d checks left unmatched, actual pending expected none", q_cyc.size());
      end
      finish_run();
   end
endmodule